// File: doc/BRIEF.md
# Free-Running Timer Counter with Coherent Byte Read

This block keeps a 16-bit up-counter that runs continuously from the system clock through a fixed divide-by-four prescaler. An 8-bit processor reads the counter as two bytes. The processor reads the high byte first. That read freezes the low byte in a holding buffer, so the two bytes it collects always come from one instant, even if the counter moves between the reads.

The counter is visible at two aliased byte pairs. Both pairs return the same data. They differ only in how a low-byte read interacts with the overflow flag. The flag sets when the counter rolls over from all ones to zero. Software clears it in two steps: it reads the status register while the flag is set, then it reads the low byte of the primary pair. A low-byte read of the alternate pair never counts toward the clear. A polling routine can therefore sample the time through the alternate pair without losing a pending overflow. The interrupt output follows the flag, gated by an enable bit in a small control register.

Reads use a simple synchronous strobe. Read data is registered and appears on the cycle after the strobe.

Top module: `frt_coherent_timer`

## Requirements
- R1: During reset, and in the cycle after it, the counter holds all ones minus three (0xFFFC at the default width). In that cycle the overflow flag, the interrupt enable, the interrupt output and the read data are all 0.
- R2: The counter advances by one once every four clocks and wraps from all ones to zero.
- R3: Writes to offsets 0 to 3 have no effect on the counter value or on its advance.
- R4: Offset 0 (primary high) and offset 2 (alternate high) return the live high byte. Offset 1 (primary low) and offset 3 (alternate low) return the live low byte when no high-byte read is pending.
- R5: A high-byte read at either pair, with no sequence already open, copies the current low byte into a buffer. The next low-byte read at either pair returns that buffer and closes the sequence.
- R6: More high-byte reads while a sequence is open do not refresh the buffer.
- R7: The overflow flag sets on the wrap from all ones to zero. The flag reads as the top bit of the status register at offset 4 (bit 7 at the default width). All other status bits read 0.
- R8: A status read made while the flag is set arms the clear. A later primary low-byte read (offset 1) then clears the flag.
- R9: A low-byte read at offset 3 never clears the flag and does not cancel an armed clear.
- R10: If a wrap occurs after the clear is armed, the arming is cancelled. The following primary low-byte read then leaves the flag set.
- R11: The control register at offset 5 holds the interrupt enable in bit width-3 (bit 5 at the default width). It is writable and reads back in place. The interrupt output is high exactly while the flag and the enable are both 1.
- R12: Read data is registered and appears one clock after the read strobe. It holds between reads. Offsets 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Registered read data |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The bench aims at the coherence window. It reads the high byte, leaves many cycles before the low byte, and mixes the two pairs inside one sequence. A design that reloaded the buffer on a second high read, or returned the live byte, would hand back a low byte that disagrees with the reference. The clear protocol is driven in the three orders that matter: arm and clear on the primary pair; arm, read the alternate low byte, then clear; and arm, let a second wrap happen, then read the primary low byte. These catch a flag cleared by the wrong pair, an arm that survives a new overflow, and a clear that needs no arm at all. Writes to the counter offsets sit between two live reads whose spacing fixes the expected difference, so a counter that accepts writes shows up at once.

// File: rtl/frt_pkg.sv
package frt_pkg;
  // Byte offsets; order is relied on by bench and software.
  localparam int unsigned OFS_PRI_HI = 0;
  localparam int unsigned OFS_PRI_LO = 1;
  localparam int unsigned OFS_ALT_HI = 2;
  localparam int unsigned OFS_ALT_LO = 3;
  localparam int unsigned OFS_STATUS = 4;
  localparam int unsigned OFS_CTRL   = 5;

  typedef struct packed {
    logic rd_hi;     // high byte read, either pair
    logic rd_lo;     // low byte read, either pair
    logic rd_pri_lo; // primary low read (clear path)
    logic rd_stat;   // status read
    logic wr_ctrl;   // control write
  } frt_dec_t;
endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst)                phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                    phase_q <= phase_q + PW'(1);
  end

  assign tick_o = (phase_q == LAST);
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] RST_VAL = {W{1'b1}} - W'(3);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= RST_VAL;
    else if (tick_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i & (&cnt_q);
endmodule

// File: rtl/frt_lo_latch.sv
module frt_lo_latch #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_hi_i,
  input  logic          rd_lo_i,
  input  logic [BW-1:0] live_lo_i,
  output logic [BW-1:0] lo_data_o,
  output logic          held_o,
  output logic [BW-1:0] held_byte_o
);
  logic          held_q;
  logic [BW-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
      byte_q <= '0;
    end else if (rd_lo_i) begin
      held_q <= 1'b0;
    end else if (rd_hi_i && !held_q) begin
      held_q <= 1'b1;
      byte_q <= live_lo_i;
    end
  end

  assign lo_data_o   = held_q ? byte_q : live_lo_i;
  assign held_o      = held_q;
  assign held_byte_o = byte_q;
endmodule

// File: rtl/frt_ovf_flag.sv
module frt_ovf_flag (
  input  logic clk,
  input  logic rst,
  input  logic wrap_i,
  input  logic stat_rd_i,
  input  logic pri_lo_rd_i,
  output logic flag_o
);
  logic flag_q;
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (wrap_i) begin
      flag_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (pri_lo_rd_i && armed_q) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (stat_rd_i && flag_q) begin
      armed_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/frt_coherent_timer.sv
module frt_coherent_timer
  import frt_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int ADDR_W   = 3,
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              ovf_irq
);
  localparam int CNT_W   = 2 * BUS_W;
  localparam int TOF_BIT = BUS_W - 1;
  localparam int IE_BIT  = BUS_W - 3;

  frt_dec_t          dec;
  logic              tick;
  logic              wrap;
  logic [CNT_W-1:0]  cnt_q;
  logic [BUS_W-1:0]  lo_data;
  logic              buf_valid;
  logic [BUS_W-1:0]  buf_byte;
  logic              tof;
  logic              ie_q;
  logic [BUS_W-1:0]  rd_mux;
  logic              hi_rd;

  always_comb begin
    dec.rd_hi     = bus_rd && (bus_addr == ADDR_W'(OFS_PRI_HI) || bus_addr == ADDR_W'(OFS_ALT_HI));
    dec.rd_lo     = bus_rd && (bus_addr == ADDR_W'(OFS_PRI_LO) || bus_addr == ADDR_W'(OFS_ALT_LO));
    dec.rd_pri_lo = bus_rd && (bus_addr == ADDR_W'(OFS_PRI_LO));
    dec.rd_stat   = bus_rd && (bus_addr == ADDR_W'(OFS_STATUS));
    dec.wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  end
  assign hi_rd = dec.rd_hi;

  frt_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  frt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick), .cnt_o(cnt_q), .wrap_o(wrap)
  );

  frt_lo_latch #(.BW(BUS_W)) u_latch (
    .clk(clk), .rst(rst),
    .rd_hi_i(dec.rd_hi), .rd_lo_i(dec.rd_lo),
    .live_lo_i(cnt_q[BUS_W-1:0]),
    .lo_data_o(lo_data), .held_o(buf_valid), .held_byte_o(buf_byte)
  );

  frt_ovf_flag u_flag (
    .clk(clk), .rst(rst), .wrap_i(wrap),
    .stat_rd_i(dec.rd_stat), .pri_lo_rd_i(dec.rd_pri_lo),
    .flag_o(tof)
  );

  always_ff @(posedge clk) begin
    if (rst)              ie_q <= 1'b0;
    else if (dec.wr_ctrl) ie_q <= bus_wdata[IE_BIT];
  end

  always_comb begin
    rd_mux = '0;
    if (dec.rd_hi)                                rd_mux = cnt_q[CNT_W-1:BUS_W];
    else if (dec.rd_lo)                           rd_mux = lo_data;
    else if (bus_addr == ADDR_W'(OFS_STATUS))     rd_mux[TOF_BIT] = tof;
    else if (bus_addr == ADDR_W'(OFS_CTRL))       rd_mux[IE_BIT] = ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign ovf_irq = tof & ie_q;
endmodule

// File: rtl/frt_timer_checker.sv
module frt_timer_checker
  import frt_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_rd,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 ovf_irq,
  input logic                 tick,
  input logic                 wrap,
  input logic [2*BUS_W-1:0]   cnt,
  input logic                 tof,
  input logic                 hi_rd,
  input logic                 buf_valid,
  input logic [BUS_W-1:0]     buf_byte
);
  localparam int CW = 2 * BUS_W;
  localparam logic [CW-1:0] RST_VAL = {CW{1'b1}} - CW'(3);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (cnt == RST_VAL && !tof && !ovf_irq));

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> cnt == $past(cnt) + CW'(1));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  // R3: a write never disturbs the count beyond its normal advance
  a_r3_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !tick && bus_addr < ADDR_W'(4)) |=> $stable(cnt));

  a_r6_buffer_frozen: assert property (@(posedge clk) disable iff (rst)
    (buf_valid && hi_rd) |=> (buf_valid && $stable(buf_byte)));

  a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
    wrap |=> tof);

  a_r9_alt_no_clear: assert property (@(posedge clk) disable iff (rst)
    (tof && bus_rd && bus_addr == ADDR_W'(OFS_ALT_LO)) |=> tof);
endmodule

bind frt_coherent_timer frt_timer_checker #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .ovf_irq(ovf_irq), .tick(tick), .wrap(wrap), .cnt(cnt_q), .tof(tof),
  .hi_rd(hi_rd), .buf_valid(buf_valid), .buf_byte(buf_byte)
);

// File: tb/frt_coherent_timer_bench.sv
module frt_coherent_timer_bench;
  localparam int BW   = 6;            // narrow bus keeps two wraps within budget
  localparam int CW   = 2 * BW;
  localparam int MAXC = (1 << CW) - 1;
  localparam int BMSK = (1 << BW) - 1;
  localparam int TOFV = 1 << (BW - 1);
  localparam int IEV  = 1 << (BW - 3);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    bus_addr = '0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [BW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_rdata;
  logic          ovf_irq;

  always #10 clk = ~clk;

  frt_coherent_timer #(.BUS_W(BW)) u_frt_coherent_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_irq(ovf_irq)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";

  // behavioural reference model
  int m_pre, m_cnt, m_bufv, m_buf, m_tof, m_arm, m_ie, m_rdata;

  always @(posedge clk) begin
    int a;
    bit wrapn;
    a = int'(bus_addr);
    if (rst) begin
      m_pre = 0; m_cnt = MAXC - 3; m_bufv = 0; m_buf = 0;
      m_tof = 0; m_arm = 0; m_ie = 0; m_rdata = 0;
    end else begin
      wrapn = (m_pre == 3) && (m_cnt == MAXC);
      if (bus_rd) begin
        case (a)
          0, 2:    m_rdata = m_cnt >> BW;
          1, 3:    m_rdata = m_bufv ? m_buf : (m_cnt & BMSK);
          4:       m_rdata = m_tof ? TOFV : 0;
          5:       m_rdata = m_ie ? IEV : 0;
          default: m_rdata = 0;
        endcase
        if (a == 1 || a == 3) m_bufv = 0;
        else if ((a == 0 || a == 2) && m_bufv == 0) begin
          m_bufv = 1; m_buf = m_cnt & BMSK;
        end
      end
      if (wrapn) begin m_tof = 1; m_arm = 0; end
      else if (bus_rd && a == 1 && m_arm == 1) begin m_tof = 0; m_arm = 0; end
      else if (bus_rd && a == 4 && m_tof == 1) m_arm = 1;
      if (bus_wr && a == 5) m_ie = (int'(bus_wdata) & IEV) != 0;
      if (m_pre == 3) begin m_pre = 0; m_cnt = (m_cnt + 1) & MAXC; end
      else m_pre = m_pre + 1;
    end
  end

  task automatic check(input int act, input int exp, input string t);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  // per-clock comparison with the model
  always @(negedge clk) begin
    if (!rst) begin
      check(int'(bus_rdata), m_rdata, tag);
      check(int'(ovf_irq), (m_tof != 0 && m_ie != 0) ? 1 : 0, "R11");
    end
  end

  task automatic rd(input int a, output int v);
    bus_rd = 1'b1; bus_addr = 3'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    v = int'(bus_rdata);
  endtask

  task automatic wr(input int a, input int d);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = BW'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(3);
    check(int'(bus_rdata), 0, "R1");
    check(int'(ovf_irq), 0, "R1");
    rst = 1'b0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      errors++; checks++;
      $display("FAIL watchdog: got %0d cycles expected under 200000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v, v1, v2;
    @(negedge clk);
    do_reset();
    // R1 / R5: high byte of reset value, then the frozen low byte
    tag = "R1"; rd(0, v); check(v, BMSK, "R1");
    tag = "R5"; rd(1, v); check(v, (MAXC - 3) & BMSK, "R5");
    // R2: live low reads four clocks apart differ by one
    tag = "R2"; rd(3, v1); idle(3); rd(3, v2); check(v2, (v1 + 1) & BMSK, "R2");
    // R7: first wrap sets the flag; this read also arms the clear
    idle(20);
    tag = "R7"; rd(4, v); check(v, TOFV, "R7");
    // R9: alternate low read leaves flag and arm alone
    tag = "R9"; rd(3, v); rd(4, v); check(v, TOFV, "R9");
    // R8: primary low read completes the clear
    tag = "R8"; rd(1, v); rd(4, v); check(v, 0, "R8");
    // R3: three writes between live reads four clocks apart
    tag = "R3"; rd(3, v1); wr(0, 0); wr(1, 0); wr(2, 0); rd(3, v2);
    check(v2, (v1 + 1) & BMSK, "R3");
    // R4: live high and low at both pairs
    tag = "R4"; rd(2, v); idle(2); rd(3, v); idle(5); rd(1, v); rd(0, v); idle(1); rd(1, v);
    // R6: repeated high reads keep the first snapshot
    tag = "R6"; rd(2, v); idle(10); rd(0, v); idle(10); rd(2, v); idle(7); rd(3, v);
    tag = "R5"; rd(0, v); idle(13); rd(3, v); rd(2, v); idle(9); rd(1, v);
    // R11: enable bit write and readback
    tag = "R11"; wr(5, IEV); rd(5, v); check(v, IEV, "R11");
    check(int'(ovf_irq), 0, "R11");
    // R12: unused offsets and hold between reads
    tag = "R12"; rd(6, v); check(v, 0, "R12"); rd(7, v); check(v, 0, "R12");
    rd(5, v); idle(3); check(int'(bus_rdata), IEV, "R12");
    // R10: new wrap between arm and primary low read
    do_reset();
    tag = "R10"; wr(5, IEV); idle(25);
    check(int'(ovf_irq), 1, "R11");
    idle(16280);
    rd(4, v); check(v, TOFV, "R10");
    idle(200);
    rd(1, v); rd(4, v); check(v, TOFV, "R10");
    tag = "R8"; rd(1, v); rd(4, v); check(v, 0, "R8");
    check(int'(ovf_irq), 0, "R11");
    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule